// File: doc/BRIEF.md
# SDRAM Command Spacing Guard

This block sits between an SDRAM command sequencer and the DRAM pin logic. It decides, one cycle at a time, whether the command that the sequencer presents may go out. The sequencer drives a command code, a bank number and a valid flag. In the same cycle, the guard raises `cmd_grant` only if every minimum spacing that applies to that command has run out. Each spacing is timed by its own down-counter. The counter is loaded when the governing command is granted, and it holds back the dependent commands while it is nonzero.

The spacings come from two byte-wide set-up registers that software writes and reads. In each timing field, the code zero selects the longest delay, so the block starts with conservative timing. A cold reset clears the registers and the spacing history. A hot reset clears only the spacing history and keeps the programmed timing. After an AUTO REFRESH, a fixed gap blocks all commands, whatever value tRC holds.

Top module: `sdr_cmd_guard`

## Requirements
- R1: Command codes on `cmd_op` are 0 none, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 MODE REGISTER SET, 6 AUTO REFRESH, and 7 is unused. `cmd_grant` is high only in a cycle where `cmd_valid` is high and the code is 1 to 6, and it responds combinationally in that same cycle. At most one command is granted per clock.
- R2: `reg_sel`=0 addresses timing register A. Its bits [4:3] hold tRP, bits [2:0] hold tRC, and bits [7:5] read as 0. `reg_sel`=1 addresses timing register B. Its bits [7:6] hold tRCD, bit 5 holds tRSC, bits [4:3] hold tRRD, and bits [2:0] read as 0. A write with `reg_wr` high takes effect at the clock edge. `reg_rdata` always shows the selected register.
- R3: While `cold_rst_n` is low, no command is granted. After a cold reset, both registers read 0x00.
- R4: A hot reset (`hot_rst_n` low) blocks grants while it is asserted and keeps every register field. It also clears all pending spacings, so an ACTIVE right after hot reset is granted even if a PRECHARGE was issued just before.
- R5: For the 2-bit fields, codes 1 to 3 mean 1 to 3 clocks and code 0 means 4 clocks. For tRC, codes 1 to 7 mean 1 to 7 clocks and code 0 means 8 clocks. For tRSC, 1 means 1 clock and 0 means 2 clocks. A spacing of N clocks, started by a grant in cycle t, allows the dependent command from cycle t+N.
- R6: ACTIVE, MODE REGISTER SET and AUTO REFRESH wait tRP after a granted PRECHARGE.
- R7: READ and WRITE to bank b wait tRCD after a granted ACTIVE to bank b.
- R8: ACTIVE to bank b waits tRC after a granted ACTIVE to that same bank.
- R9: Any ACTIVE waits tRRD after any granted ACTIVE.
- R10: After a granted AUTO REFRESH, all commands are blocked for REF_GAP clocks (default 3), independent of tRC.
- R11: After a granted MODE REGISTER SET, all commands are blocked for the tRSC period.
- R12: A spacing uses the field values in place in the cycle of its grant. A register write in that same cycle applies only to later grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, synchronous; clears registers and spacings |
| hot_rst_n | input | 1 | Hot reset, active low, synchronous; clears spacings only |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 timing A, 1 timing B |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| cmd_valid | input | 1 | Command request present |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BANK_W | Bank number for ACTIVE, READ and WRITE |
| cmd_grant | output | 1 | Command may issue this cycle |

## Verification
Directed sequences first measure the ACTIVE-after-PRECHARGE latency with cold-reset timing, where the code-zero fields must give 4 clocks. They then change tRP in the very cycle of a PRECHARGE grant, which separates capture at grant time from capture at check time. A hot reset placed right after a PRECHARGE shows whether the spacing history was cleared while the fields were kept. Random commands, banks, register writes and occasional resets then exercise the interaction of same-bank tRC, cross-bank tRRD, per-bank tRCD and the refresh and mode-set gaps. In every cycle the grant is compared with a bench model that tracks the next allowed cycle of each spacing.

// File: rtl/sdr_guard_pkg.sv
package sdr_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_MRS = 3'd5,
    OP_REF = 3'd6
  } sdr_op_e;

  localparam int CNT_W = 3;

  // Clock count selected by a field code; code zero picks 2**bits.
  function automatic logic [3:0] span_cycles(input logic [2:0] code, input int unsigned bits);
    if (code == 3'd0) return 4'(1 << bits);
    return {1'b0, code};
  endfunction

  // Counter preload: a span of N clocks holds for N-1 cycles after the grant.
  function automatic logic [CNT_W-1:0] span_load(input logic [3:0] cycles);
    return CNT_W'(cycles - 4'd1);
  endfunction

endpackage

// File: rtl/sdr_span_ctr.sv
module sdr_span_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sdr_timing_regs.sv
module sdr_timing_regs (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       wr,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [1:0] f_trp,
  output logic [2:0] f_trc,
  output logic [1:0] f_trcd,
  output logic       f_trsc,
  output logic [1:0] f_trrd
);
  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      f_trp  <= '0;
      f_trc  <= '0;
      f_trcd <= '0;
      f_trsc <= 1'b0;
      f_trrd <= '0;
    end else if (wr) begin
      if (!sel) begin
        f_trp <= wdata[4:3];
        f_trc <= wdata[2:0];
      end else begin
        f_trcd <= wdata[7:6];
        f_trsc <= wdata[5];
        f_trrd <= wdata[4:3];
      end
    end
  end

  assign rdata = sel ? {f_trcd, f_trsc, f_trrd, 3'b000}
                     : {3'b000, f_trp, f_trc};
endmodule

// File: rtl/sdr_cmd_guard.sv
module sdr_cmd_guard #(
  parameter  int NUM_BANKS = 4,
  parameter  int REF_GAP   = 3,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              hot_rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_grant
);
  import sdr_guard_pkg::*;

  logic [1:0] f_trp, f_trcd, f_trrd;
  logic [2:0] f_trc;
  logic       f_trsc;
  logic       rst_any;
  sdr_op_e    op;

  assign rst_any = !cold_rst_n || !hot_rst_n;
  assign op      = sdr_op_e'(cmd_op);

  sdr_timing_regs u_regs (
    .clk(clk), .cold_rst_n(cold_rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .f_trp(f_trp), .f_trc(f_trc), .f_trcd(f_trcd), .f_trsc(f_trsc), .f_trrd(f_trrd)
  );

  // Named grant events, also observed by the checker.
  logic fire_act, fire_pre, fire_mrs, fire_ref;
  assign fire_act = cmd_grant && (op == OP_ACT);
  assign fire_pre = cmd_grant && (op == OP_PRE);
  assign fire_mrs = cmd_grant && (op == OP_MRS);
  assign fire_ref = cmd_grant && (op == OP_REF);

  logic rp_busy, rrd_busy, ref_busy, mrs_busy;

  sdr_span_ctr #(.W(CNT_W)) u_rp (
    .clk(clk), .clr(rst_any), .load(fire_pre),
    .load_val(span_load(span_cycles({1'b0, f_trp}, 2))), .busy(rp_busy));

  sdr_span_ctr #(.W(CNT_W)) u_rrd (
    .clk(clk), .clr(rst_any), .load(fire_act),
    .load_val(span_load(span_cycles({1'b0, f_trrd}, 2))), .busy(rrd_busy));

  sdr_span_ctr #(.W(CNT_W)) u_ref (
    .clk(clk), .clr(rst_any), .load(fire_ref),
    .load_val(CNT_W'(REF_GAP - 1)), .busy(ref_busy));

  sdr_span_ctr #(.W(CNT_W)) u_mrs (
    .clk(clk), .clr(rst_any), .load(fire_mrs),
    .load_val(f_trsc ? CNT_W'(0) : CNT_W'(1)), .busy(mrs_busy));

  logic [NUM_BANKS-1:0] bank_hit, rc_busy, rcd_busy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = (cmd_bank == BANK_W'(b));

    sdr_span_ctr #(.W(CNT_W)) u_rc (
      .clk(clk), .clr(rst_any), .load(fire_act && bank_hit[b]),
      .load_val(span_load(span_cycles(f_trc, 3))), .busy(rc_busy[b]));

    sdr_span_ctr #(.W(CNT_W)) u_rcd (
      .clk(clk), .clr(rst_any), .load(fire_act && bank_hit[b]),
      .load_val(span_load(span_cycles({1'b0, f_trcd}, 2))), .busy(rcd_busy[b]));
  end

  logic sel_rc_busy, sel_rcd_busy, gate_all, op_ok;
  assign sel_rc_busy  = |(rc_busy & bank_hit);
  assign sel_rcd_busy = |(rcd_busy & bank_hit);
  assign gate_all     = !ref_busy && !mrs_busy;

  always_comb begin
    unique case (op)
      OP_ACT:         op_ok = !rp_busy && !rrd_busy && !sel_rc_busy;
      OP_RD, OP_WR:   op_ok = !sel_rcd_busy;
      OP_PRE:         op_ok = 1'b1;
      OP_MRS, OP_REF: op_ok = !rp_busy;
      default:        op_ok = 1'b0;
    endcase
  end

  assign cmd_grant = cmd_valid && !rst_any && gate_all && op_ok;
endmodule

// File: rtl/sdr_guard_checks.sv
module sdr_guard_checks #(
  parameter int REF_GAP = 3,
  parameter int BANK_W  = 2
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              hot_rst_n,
  input logic              reg_wr,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              cmd_grant,
  input logic              fire_act,
  input logic              fire_pre,
  input logic              fire_mrs,
  input logic              fire_ref,
  input logic [1:0]        f_trp,
  input logic [2:0]        f_trc,
  input logic [1:0]        f_trcd,
  input logic              f_trsc,
  input logic [1:0]        f_trrd
);
  logic [10:0] fields;
  logic        rst_any;
  assign fields  = {f_trp, f_trc, f_trcd, f_trsc, f_trrd};
  assign rst_any = !cold_rst_n || !hot_rst_n;

  a_r1_grant_needs_valid: assert property (@(posedge clk) disable iff (rst_any)
    cmd_grant |-> cmd_valid);

  a_r3_cold_clears: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $past(!cold_rst_n) |-> (fields == 11'd0));

  a_r4_hot_keeps: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $past(!hot_rst_n && !reg_wr) |-> $stable(fields));

  a_r6_rp_spacing: assert property (@(posedge clk) disable iff (rst_any)
    ($past(fire_pre) && $past(f_trp) != 2'd1) |-> !fire_act);

  a_r7_rcd_spacing: assert property (@(posedge clk) disable iff (rst_any)
    ($past(fire_act) && $past(f_trcd) != 2'd1 && (cmd_op == 3'd2 || cmd_op == 3'd3)
     && cmd_bank == $past(cmd_bank)) |-> !cmd_grant);

  if (REF_GAP > 1) begin : g_ref
    a_r10_ref_gap: assert property (@(posedge clk) disable iff (rst_any)
      $past(fire_ref) |-> !cmd_grant);
  end

  a_r11_mrs_gap: assert property (@(posedge clk) disable iff (rst_any)
    ($past(fire_mrs) && !$past(f_trsc)) |-> !cmd_grant);
endmodule

bind sdr_cmd_guard sdr_guard_checks #(.REF_GAP(REF_GAP), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .hot_rst_n(hot_rst_n), .reg_wr(reg_wr),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_grant(cmd_grant),
  .fire_act(fire_act), .fire_pre(fire_pre), .fire_mrs(fire_mrs), .fire_ref(fire_ref),
  .f_trp(f_trp), .f_trc(f_trc), .f_trcd(f_trcd), .f_trsc(f_trsc), .f_trrd(f_trrd)
);

// File: tb/test_sdr_cmd_guard.sv
`timescale 1ns/1ps
module test_sdr_cmd_guard;
  localparam int NB  = 4;
  localparam int BW  = 2;
  localparam int GAP = 3;

  logic          clk = 1'b0;
  logic          cold_rst_n = 1'b0, hot_rst_n = 1'b1;
  logic          reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]    reg_wdata = '0, reg_rdata;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [BW-1:0] cmd_bank = '0;
  logic          cmd_grant;

  always #2.5 clk = ~clk;

  sdr_cmd_guard #(.NUM_BANKS(NB), .REF_GAP(GAP)) i_sdr_cmd_guard (
    .clk(clk), .cold_rst_n(cold_rst_n), .hot_rst_n(hot_rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_grant(cmd_grant));

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] sh_a = 8'h00, sh_b = 8'h00;
  int nx_rp = -1000, nx_rrd = -1000, nx_ref = -1000, nx_mrs = -1000;
  int nx_rc[NB], nx_rcd[NB];
  bit done = 0;

  function automatic int span(input int code, input int bits);
    return (code == 0) ? (1 << bits) : code;
  endfunction

  function automatic void clear_hist();
    nx_rp = -1000; nx_rrd = -1000; nx_ref = -1000; nx_mrs = -1000;
    for (int i = 0; i < NB; i++) begin nx_rc[i] = -1000; nx_rcd[i] = -1000; end
  endfunction

  // Returns the tag of the first spacing that holds this command back, or "".
  function automatic string blocker(input int op, input int b);
    if (cyc < nx_ref) return "R10";
    if (cyc < nx_mrs) return "R11";
    if (op == 1) begin
      if (cyc < nx_rp)    return "R6";
      if (cyc < nx_rrd)   return "R9";
      if (cyc < nx_rc[b]) return "R8";
    end
    if ((op == 2 || op == 3) && cyc < nx_rcd[b]) return "R7";
    if ((op == 5 || op == 6) && cyc < nx_rp) return "R6";
    return "";
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      1: return "R8";
      2, 3: return "R7";
      5: return "R11";
      6: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input int op, input int bank, input bit wr, input bit sel,
                      input logic [7:0] wd, input bit hot, input bit cold, output bit g);
    string blk, tag;
    bit exp_g;
    logic [7:0] exp_rd;
    @(negedge clk);
    cmd_valid = v; cmd_op = 3'(op); cmd_bank = BW'(bank);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    hot_rst_n = !hot; cold_rst_n = !cold;
    #1;
    blk   = blocker(op, bank);
    exp_g = v && !hot && !cold && op >= 1 && op <= 6 && blk == "";
    g     = cmd_grant;
    if (cold || hot) tag = cold ? "R3" : "R4";
    else tag = exp_g ? op_tag(op) : ((blk == "") ? "R1" : blk);
    chk(g == exp_g, tag, int'(g), int'(exp_g));
    if (cyc > 0) begin
      exp_rd = sel ? sh_b : sh_a;
      chk(reg_rdata == exp_rd, "R2", int'(reg_rdata), int'(exp_rd));
    end
    @(posedge clk);
    if (cold || hot) clear_hist();
    else if (g) begin
      case (op)
        1: begin
          nx_rc[bank]  = cyc + span(int'(sh_a[2:0]), 3);
          nx_rcd[bank] = cyc + span(int'(sh_b[7:6]), 2);
          nx_rrd       = cyc + span(int'(sh_b[4:3]), 2);
        end
        4: nx_rp  = cyc + span(int'(sh_a[4:3]), 2);
        5: nx_mrs = cyc + (sh_b[5] ? 1 : 2);
        6: nx_ref = cyc + GAP;
        default: ;
      endcase
    end
    if (cold) begin sh_a = 8'h00; sh_b = 8'h00; end
    else if (wr) begin
      if (sel) sh_b = wd & 8'hF8;
      else     sh_a = wd & 8'h1F;
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    bit g;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00, 0, 0, g);
  endtask

  // Requests ACTIVE every cycle until granted; returns the number of attempts.
  task automatic act_latency(input int bank, output int n);
    bit g;
    n = 0;
    do begin
      step(1, 1, bank, 0, 0, 8'h00, 0, 0, g);
      n++;
    end while (!g && n < 20);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired (cycle %0d)", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit g;
    int n;
    void'($urandom(32'd1234));
    clear_hist();
    // R3: no grant during cold reset, registers cleared
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, i[0], 8'h00, 0, 1, g);
    step(0, 0, 0, 0, 0, 8'h00, 0, 0, g);
    chk(reg_rdata == 8'h00, "R3", int'(reg_rdata), 0);
    // R5/R6: code 0 of tRP means 4 clocks
    step(1, 4, 0, 0, 0, 8'h00, 0, 0, g);
    act_latency(1, n);
    chk(n == 4, "R5", n, 4);
    idle(10);
    // R12: write tRP=1 in the cycle of the PRECHARGE grant; old value still applies
    step(1, 4, 0, 1, 0, 8'h08, 0, 0, g);
    act_latency(2, n);
    chk(n == 4, "R12", n, 4);
    idle(10);
    step(1, 4, 0, 0, 0, 8'h00, 0, 0, g);
    act_latency(3, n);
    chk(n == 1, "R12", n, 1);
    idle(10);
    // R4: hot reset keeps fields and clears spacings
    step(0, 0, 0, 1, 0, 8'h00, 0, 0, g);
    step(0, 0, 0, 1, 1, 8'hA8, 0, 0, g);
    idle(10);
    step(1, 4, 0, 0, 0, 8'h00, 0, 0, g);
    step(1, 1, 0, 0, 1, 8'h00, 1, 0, g);
    chk(reg_rdata == 8'hA8, "R4", int'(reg_rdata), 8'hA8);
    act_latency(0, n);
    chk(n == 1, "R4", n, 1);
    // R2: reserved bits read as zero
    step(0, 0, 0, 1, 0, 8'hFF, 0, 0, g);
    step(0, 0, 0, 1, 1, 8'hFF, 0, 0, g);
    step(0, 0, 0, 0, 0, 8'h00, 0, 0, g);
    chk(reg_rdata == 8'h1F, "R2", int'(reg_rdata), 8'h1F);
    step(0, 0, 0, 0, 1, 8'h00, 0, 0, g);
    chk(reg_rdata == 8'hF8, "R2", int'(reg_rdata), 8'hF8);
    // Random mix: R1 R6 R7 R8 R9 R10 R11 checked by the model every cycle
    for (int i = 0; i < 6000; i++) begin
      bit v, wr, hot, cold;
      int op, bank;
      v    = ($urandom_range(0, 3) != 0);
      op   = $urandom_range(0, 7);
      if ($urandom_range(0, 2) == 0) op = 1;
      bank = $urandom_range(0, NB - 1);
      wr   = ($urandom_range(0, 23) == 0);
      hot  = ($urandom_range(0, 499) == 0);
      cold = ($urandom_range(0, 1499) == 0);
      step(v, op, bank, wr, $urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)), hot, cold, g);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule